// File: doc/BRIEF.md
# Multithreaded Short-Circuit Row Filter

This block filters rows of a table held in a memory whose read latency is long and varies from request to request. The filter is a conjunction of up to four comparisons, each against one 32-bit column of the row. Every row index that enters the block gets its own lightweight thread. The thread holds only the row index, the number of the comparison it is working on and a three-way state: free, ready to issue, or waiting on memory.

A thread reads one column at a time. It asks for the column of the first comparison only. It asks for the next column only after the previous comparison has passed. The first failing comparison ends the thread, and the thread makes no further read. Sixteen threads can be in flight at once, so the latency of one read is hidden behind the others. The thread slot number is the memory tag, and responses may come back in any order.

A row that passes every configured comparison appears on the output as a one-cycle pulse that carries its index. Rows leave in the order their last comparison completes, not in arrival order. The comparisons are set by static configuration inputs that stay constant while rows are in flight.

Top module: `sel_engine`

## Requirements
- R1: After reset `in_ready` is 1, `req_valid` is 0 and `out_valid` is 0. A row offered while a slot is free is accepted in that cycle and starts a thread.
- R2: The read address for row r and column c is r*32 + c*4 (row index shifted left by 5, plus the 3-bit column field times 4). The first read of a row is for the column of comparison 0.
- R3: A thread has at most one read outstanding. It requests the column of comparison k+1 only after comparison k has passed, so the reads for a row follow the configured columns in order.
- R4: A failing comparison ends the thread. That row gets no further read and never appears on the output.
- R5: When all 16 slots hold threads, `in_ready` is 0 and an offered row is not taken. Such a row is never read and never emitted.
- R6: Responses are matched to threads by `rsp_tag` and may arrive in any order. Each response is judged against the comparison its thread is currently on.
- R7: Each comparison has a 3-bit operator field, compared unsigned as column OP constant: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal. Codes 6 and 7 never match.
- R8: A row that passes comparisons 0 through `cfg_last` gives exactly one `out_valid` pulse carrying its index. The pulse comes in the cycle after the response that completed the row.
- R9: A pending request holds its tag and address unchanged while `req_ready` is 0. Ready threads are granted round-robin, starting after the last slot granted.
- R10: `cfg_last` holds the number of comparisons minus one. Comparisons above `cfg_last` are never read and never judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_last | input | 2 | Index of the last comparison in use |
| cfg_col | input | 12 | Column field of each comparison, 3 bits each, comparison k at bits [3k+2:3k] |
| cfg_op | input | 12 | Operator code of each comparison, 3 bits each |
| cfg_const | input | 128 | 32-bit constant of each comparison |
| in_valid | input | 1 | A row index is offered |
| in_ready | output | 1 | A thread slot is free |
| in_row | input | 16 | Offered row index |
| req_valid | output | 1 | A memory read is pending |
| req_ready | input | 1 | Memory takes the read this cycle |
| req_tag | output | 4 | Slot number of the reading thread |
| req_addr | output | 21 | Byte address of the column |
| rsp_valid | input | 1 | Read data returns |
| rsp_tag | input | 4 | Slot number the data belongs to |
| rsp_data | input | 32 | Column value |
| out_valid | output | 1 | A row passed all comparisons |
| out_row | output | 16 | Index of the passing row |

## Verification
Three things can land on one clock edge. A response can end one thread and free its slot. A new row can take a different free slot. A request can be loaded for a third thread. The bench provokes this with a stream of rows under variable, reordering latency. A monitor counts the edges where an accepted row and a returning response coincide, and requires that count to be non-zero. Every row is then judged by its output count and by how many reads it made, compared with values the bench derives from its own comparison model, so any slot clobbered on such an edge shows up as a missing or extra output or read.

// File: rtl/sel_pkg.sv
package sel_pkg;
    localparam int OPW = 3;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_READY = 2'd1,
        SLOT_WAIT  = 2'd2
    } slot_st_e;

    typedef enum logic [OPW-1:0] {
        CMP_EQ = 3'd0,
        CMP_NE = 3'd1,
        CMP_LT = 3'd2,
        CMP_LE = 3'd3,
        CMP_GT = 3'd4,
        CMP_GE = 3'd5
    } cmp_op_e;
endpackage

// File: rtl/sel_pred_cmp.sv
module sel_pred_cmp
    import sel_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  lhs,
    input  logic [DW-1:0]  rhs,
    output logic           hit
);
    // unsigned comparison, lhs is the column value, rhs the constant
    always_comb begin
        case (op)
            CMP_EQ:  hit = (lhs == rhs);
            CMP_NE:  hit = (lhs != rhs);
            CMP_LT:  hit = (lhs <  rhs);
            CMP_LE:  hit = (lhs <= rhs);
            CMP_GT:  hit = (lhs >  rhs);
            CMP_GE:  hit = (lhs >= rhs);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sel_rr_pick.sv
module sel_rr_pick #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] ptr,
    output logic         any,
    output logic [W-1:0] idx
);
    // first requester at or after ptr, wrapping; N is a power of two
    always_comb begin
        logic [W-1:0] cand;
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            cand = ptr + W'(i);
            if (!any && req[cand]) begin
                any = 1'b1;
                idx = cand;
            end
        end
    end
endmodule

// File: rtl/sel_free_pick.sv
module sel_free_pick #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] free,
    output logic         any,
    output logic [W-1:0] idx
);
    // lowest free slot
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) idx = W'(i);
        end
        any = |free;
    end
endmodule

// File: rtl/sel_engine.sv
module sel_engine
    import sel_pkg::*;
#(
    parameter int NSLOT     = 16,
    parameter int NPRED     = 4,
    parameter int DW        = 32,
    parameter int RW        = 16,
    parameter int COLW      = 3,
    parameter int ROW_SHIFT = 5,
    localparam int TW = $clog2(NSLOT),
    localparam int SW = $clog2(NPRED),
    localparam int AW = RW + ROW_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SW-1:0]         cfg_last,
    input  logic [NPRED*COLW-1:0] cfg_col,
    input  logic [NPRED*OPW-1:0]  cfg_op,
    input  logic [NPRED*DW-1:0]   cfg_const,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [RW-1:0]         in_row,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [TW-1:0]         req_tag,
    output logic [AW-1:0]         req_addr,
    input  logic                  rsp_valid,
    input  logic [TW-1:0]         rsp_tag,
    input  logic [DW-1:0]         rsp_data,
    output logic                  out_valid,
    output logic [RW-1:0]         out_row
);
    typedef struct packed {
        slot_st_e [NSLOT-1:0]         st;
        logic [NSLOT-1:0][RW-1:0]     row;
        logic [NSLOT-1:0][SW-1:0]     step;
        logic                         req_v;
        logic [TW-1:0]                req_tag;
        logic [AW-1:0]                req_addr;
        logic [TW-1:0]                rr_ptr;
        logic                         out_v;
        logic [RW-1:0]                out_row;
    } eng_st_t;

    eng_st_t q, d;

    logic [NSLOT-1:0] free_vec;
    logic [NSLOT-1:0] ready_vec;
    logic             alloc_any;
    logic [TW-1:0]    alloc_idx;
    logic             grant_any;
    logic [TW-1:0]    grant_idx;
    logic             accept;
    logic             rsp_hit;
    logic             pred_ok;
    logic             req_load;
    logic [SW-1:0]    rsp_step;
    logic [OPW-1:0]   rsp_op;
    logic [DW-1:0]    rsp_const;
    logic [SW-1:0]    grant_step;
    logic [COLW-1:0]  grant_col;

    // slot occupancy views
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            free_vec[i]  = (q.st[i] == SLOT_FREE);
            ready_vec[i] = (q.st[i] == SLOT_READY);
        end
    end

    sel_free_pick #(.N(NSLOT)) u_free (
        .free (free_vec),
        .any  (alloc_any),
        .idx  (alloc_idx)
    );

    sel_rr_pick #(.N(NSLOT)) u_rr (
        .req  (ready_vec),
        .ptr  (q.rr_ptr),
        .any  (grant_any),
        .idx  (grant_idx)
    );

    assign in_ready = alloc_any;
    assign accept   = in_valid && alloc_any;

    // judging the returning column against its thread's current comparison
    assign rsp_hit   = rsp_valid && (q.st[rsp_tag] == SLOT_WAIT);
    assign rsp_step  = q.step[rsp_tag];
    assign rsp_op    = cfg_op[int'(rsp_step)*OPW +: OPW];
    assign rsp_const = cfg_const[int'(rsp_step)*DW +: DW];

    sel_pred_cmp #(.DW(DW)) u_cmp (
        .op   (rsp_op),
        .lhs  (rsp_data),
        .rhs  (rsp_const),
        .hit  (pred_ok)
    );

    // column of the granted thread's current comparison
    assign grant_step = q.step[grant_idx];
    assign grant_col  = cfg_col[int'(grant_step)*COLW +: COLW];
    assign req_load   = !q.req_v || req_ready;

    always_comb begin
        d       = q;
        d.out_v = 1'b0;

        // new thread in the lowest free slot
        if (accept) begin
            d.st[alloc_idx]   = SLOT_READY;
            d.row[alloc_idx]  = in_row;
            d.step[alloc_idx] = '0;
        end

        // one evaluation per cycle, on the returning response
        if (rsp_hit) begin
            if (!pred_ok) begin
                d.st[rsp_tag] = SLOT_FREE;
            end else if (rsp_step == cfg_last) begin
                d.st[rsp_tag] = SLOT_FREE;
                d.out_v       = 1'b1;
                d.out_row     = q.row[rsp_tag];
            end else begin
                d.step[rsp_tag] = rsp_step + SW'(1);
                d.st[rsp_tag]   = SLOT_READY;
            end
        end

        // one request per cycle, held while memory stalls
        if (req_load) begin
            d.req_v = grant_any;
            if (grant_any) begin
                d.req_tag       = grant_idx;
                d.req_addr      = {q.row[grant_idx], {ROW_SHIFT{1'b0}}}
                                  + (AW'(grant_col) << 2);
                d.st[grant_idx] = SLOT_WAIT;
                d.rr_ptr        = grant_idx + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_valid = q.req_v;
    assign req_tag   = q.req_tag;
    assign req_addr  = q.req_addr;
    assign out_valid = q.out_v;
    assign out_row   = q.out_row;
endmodule

// File: rtl/sel_engine_chk.sv
module sel_engine_chk #(
    parameter int NSLOT     = 16,
    parameter int RW        = 16,
    parameter int ROW_SHIFT = 5,
    localparam int TW = $clog2(NSLOT),
    localparam int AW = RW + ROW_SHIFT
) (
    input logic          clk,
    input logic          rst_n,
    input logic          accept,
    input logic [TW-1:0] alloc_idx,
    input logic [RW-1:0] in_row,
    input logic          req_valid,
    input logic          req_ready,
    input logic [TW-1:0] req_tag,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic [TW-1:0] rsp_tag,
    input logic          out_valid,
    input logic [RW-1:0] out_row
);
    logic [RW-1:0]    row_of [NSLOT];
    logic [NSLOT-1:0] pend;
    logic [RW-1:0]    last_rsp_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) row_of[i] <= '0;
            pend         <= '0;
            last_rsp_row <= '0;
        end else begin
            if (accept) row_of[alloc_idx] <= in_row;
            if (rsp_valid) begin
                pend[rsp_tag] <= 1'b0;
                last_rsp_row  <= row_of[rsp_tag];
            end
            if (req_valid && req_ready) pend[req_tag] <= 1'b1;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_tag) && $stable(req_addr));

    // R3
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> !pend[req_tag]);

    // R2
    addr_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[AW-1:ROW_SHIFT] == row_of[req_tag]);

    // R8
    out_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rsp_valid) && out_row == last_rsp_row);
endmodule

bind sel_engine sel_engine_chk #(
    .NSLOT     (NSLOT),
    .RW        (RW),
    .ROW_SHIFT (ROW_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .alloc_idx (alloc_idx),
    .in_row    (in_row),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_tag   (req_tag),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .out_valid (out_valid),
    .out_row   (out_row)
);

// File: tb/tb_sel_engine.sv
module tb_sel_engine;
    localparam int NSLOT = 16;
    localparam int NPRED = 4;
    localparam int NROWS = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cfg_last;
    logic [11:0]  cfg_col;
    logic [11:0]  cfg_op;
    logic [127:0] cfg_const;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [15:0]  in_row = '0;
    logic         req_valid;
    logic         req_ready = 1'b1;
    logic [3:0]   req_tag;
    logic [20:0]  req_addr;
    logic         rsp_valid = 1'b0;
    logic [3:0]   rsp_tag = '0;
    logic [31:0]  rsp_data = '0;
    logic         out_valid;
    logic [15:0]  out_row;

    int bc_last = 0;
    int bc_col [NPRED];
    int bc_op [NPRED];
    int unsigned bc_const [NPRED];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int got [NROWS];
    int rd_cnt [NROWS];
    bit pend [NSLOT];
    int unsigned paddr [NSLOT];
    int pdly [NSLOT];
    int npend = 0;
    int nreq = 0;
    int lat_var = 0;
    bit stall = 0;
    int log_tag [32];
    int log_n = 0;
    int prev_out = -1;
    int inversions = 0;
    int coincide = 0;

    always #5 clk = ~clk;

    always_comb begin
        cfg_last = 2'(bc_last);
        for (int k = 0; k < NPRED; k++) begin
            cfg_col[k*3 +: 3]    = 3'(bc_col[k]);
            cfg_op[k*3 +: 3]     = 3'(bc_op[k]);
            cfg_const[k*32 +: 32] = bc_const[k];
        end
    end

    sel_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_last(cfg_last), .cfg_col(cfg_col),
        .cfg_op(cfg_op), .cfg_const(cfg_const), .in_valid(in_valid),
        .in_ready(in_ready), .in_row(in_row), .req_valid(req_valid),
        .req_ready(req_ready), .req_tag(req_tag), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_row(out_row)
    );

    function automatic int unsigned colval(int r, int c);
        return (r * (2 * c + 3) + c * 7) % 64;
    endfunction

    function automatic bit cmpf(int op, int unsigned a, int unsigned b);
        case (op)
            0: return a == b;
            1: return a != b;
            2: return a < b;
            3: return a <= b;
            4: return a > b;
            5: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory model, output collector and request checks
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (rst_n) begin
            if (out_valid) begin
                if (out_row < NROWS) got[out_row]++;
                if (prev_out >= 0 && int'(out_row) < prev_out) inversions++;
                prev_out = out_row;
            end
            for (int t = 0; t < NSLOT; t++) if (pend[t] && pdly[t] > 0) pdly[t]--;
            for (int t = 0; t < NSLOT; t++) begin
                if (!rsp_valid && pend[NSLOT-1-t] && pdly[NSLOT-1-t] == 0) begin
                    rsp_valid = 1'b1;
                    rsp_tag   = 4'(NSLOT-1-t);
                    rsp_data  = colval(int'(paddr[NSLOT-1-t] >> 5), int'((paddr[NSLOT-1-t] >> 2) & 7));
                    pend[NSLOT-1-t] = 1'b0;
                    npend--;
                end
            end
            req_ready = !stall;
            if (req_valid && req_ready) begin
                int r;
                int c;
                r = int'(req_addr >> 5);
                c = int'((req_addr >> 2) & 7);
                if (pend[req_tag]) check("R3", "second read on busy tag", 1, 0);
                if (rd_cnt[r] > bc_last) check("R10", "read beyond last comparison", rd_cnt[r], bc_last);
                else if (c != bc_col[rd_cnt[r]]) check("R3", "column order", c, bc_col[rd_cnt[r]]);
                if (req_addr[1:0] != 2'b00) check("R2", "address alignment", int'(req_addr[1:0]), 0);
                rd_cnt[r]++;
                pend[req_tag]  = 1'b1;
                paddr[req_tag] = req_addr;
                pdly[req_tag]  = lat_var ? ((int'(req_tag) * 5 + nreq) % 9) + 1 : 1;
                npend++;
                nreq++;
                if (log_n < 32) begin
                    log_tag[log_n] = req_tag;
                    log_n++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (in_valid && in_ready && rsp_valid) coincide++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send_row(input int r);
        in_row   = 16'(r);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int quiet = 0;
        while (quiet < 12) begin
            @(negedge clk);
            if (npend == 0 && !req_valid && !rsp_valid) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic check_rows(input int lo, input int hi, input string tag);
        for (int r = lo; r <= hi; r++) begin
            bit p = 1'b1;
            int n = 0;
            for (int k = 0; k <= bc_last; k++) begin
                n++;
                if (!cmpf(bc_op[k], colval(r, bc_col[k]), bc_const[k])) begin
                    p = 1'b0;
                    break;
                end
            end
            check(tag, $sformatf("row %0d outputs", r), got[r], p ? 1 : 0);
            check(p ? "R3" : "R4", $sformatf("row %0d reads", r), rd_cnt[r], n);
        end
    endtask

    task automatic set_pred(input int k, input int col, input int op, input int unsigned cst);
        bc_col[k]   = col;
        bc_op[k]    = op;
        bc_const[k] = cst;
    endtask

    task automatic t_reset();
        check("R1", "in_ready after reset", int'(in_ready), 1);
        check("R1", "req_valid after reset", int'(req_valid), 0);
        check("R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    // single comparison, fixed latency
    task automatic t_single();
        bc_last = 0;
        set_pred(0, 1, 2, 30);
        lat_var = 0;
        for (int r = 0; r < 20; r++) send_row(r);
        drain();
        check_rows(0, 19, "R8 R10");
    endtask

    // four comparisons, reordering latency, continuous input
    task automatic t_chain();
        bc_last = 3;
        set_pred(0, 4, 5, 10);
        set_pred(1, 0, 1, 5);
        set_pred(2, 6, 3, 50);
        set_pred(3, 2, 4, 8);
        lat_var = 1;
        inversions = 0;
        coincide = 0;
        prev_out = -1;
        for (int r = 20; r < 100; r++) send_row(r);
        drain();
        check_rows(20, 99, "R6 R8");
        check("R6", "out-of-order completions seen", int'(inversions > 0), 1);
        check("R8", "accept and response on one edge", int'(coincide > 0), 1);
    endtask

    // full occupancy, stalled memory, then round-robin order on release
    task automatic t_full();
        bc_last = 1;
        set_pred(0, 3, 5, 0);
        set_pred(1, 5, 3, 63);
        lat_var = 0;
        stall = 1;
        for (int r = 100; r < 116; r++) send_row(r);
        @(negedge clk);
        check("R5", "in_ready with all slots busy", int'(in_ready), 0);
        check("R9", "request pending under stall", int'(req_valid), 1);
        check("R9", "stalled tag", int'(req_tag), 0);
        in_row = 16'd300;
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check("R9", "stalled tag held", int'(req_tag), 0);
        check("R9", "stalled address held", int'(req_addr), 100 * 32 + 3 * 4);
        log_n = 0;
        stall = 0;
        drain();
        for (int i = 0; i < 16; i++) check("R9", $sformatf("grant %0d tag", i), log_tag[i], i);
        check("R5", "rejected row reads", rd_cnt[300], 0);
        check("R5", "rejected row outputs", got[300], 0);
        check_rows(100, 115, "R5");
    endtask

    // every operator code, constant equal to a real column value
    task automatic t_ops();
        lat_var = 1;
        for (int op = 0; op < 8; op++) begin
            int base = 120 + op * 12;
            bc_last = 0;
            set_pred(0, 2, op, colval(base + 3, 2));
            for (int r = base; r < base + 12; r++) send_row(r);
            drain();
            check_rows(base, base + 11, "R7");
        end
    endtask

    initial begin
        for (int i = 0; i < NROWS; i++) begin
            got[i] = 0;
            rd_cnt[i] = 0;
        end
        for (int t = 0; t < NSLOT; t++) begin
            pend[t] = 1'b0;
            paddr[t] = 0;
            pdly[t] = 0;
        end
        for (int k = 0; k < NPRED; k++) set_pred(k, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_full();
        t_ops();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule